// File: doc/BRIEF.md
# Pin-Change Interrupt Unit

This block watches a 32-line input port and turns level changes into latched per-line event flags, then folds those flags into four interrupt requests, one for each group of eight neighbouring lines. Each line has its own enable bit, a two-bit trigger choice (either transition, rising only, falling only) and an optional two-sample glitch filter. Software reads the flags to find which lines fired and removes them by writing ones to a clear address. A clear only acts on lines whose enable bit is set.

Inputs cross into the clock domain through a two-flop synchronizer. Each line then runs a four-state machine that holds the accepted level: `ST_LOW`, `ST_RISING`, `ST_HIGH` and `ST_FALLING`. With the filter off, `ST_LOW` goes straight to `ST_HIGH` when a high sample arrives (transition *accept-rise*), and `ST_HIGH` goes straight to `ST_LOW` on a low sample (*accept-fall*). With the filter on, the first differing sample moves the machine to a candidate state (*arm-rise* to `ST_RISING`, *arm-fall* to `ST_FALLING`). A second equal sample confirms it (*confirm-rise* to `ST_HIGH`, *confirm-fall* to `ST_LOW`). A differing sample drops it back (*reject-rise* to `ST_LOW`, *reject-fall* to `ST_HIGH`). Every accept or confirm emits a one-cycle event. While the module clock enable is low the synchronizer and the machines hold their state and no flag can be set. Register writes and reads keep working.

Top module: `pcw_irq_top`

## Requirements
- R1: After reset the enable (address 0), trigger-low (1), trigger-high (2) and filter (3) registers read zero, the flag register (4) reads zero and all four `irq` bits are 0.
- R2: With trigger bits {high[i],low[i]} equal to 00 or 11, both a rising and a falling level on line i set flag i.
- R3: With {high[i],low[i]} = 01 a rising level sets flag i and a falling level does not.
- R4: With {high[i],low[i]} = 10 a falling level sets flag i and a rising level does not.
- R5: A flag is set only if the line's enable bit is 1 when the event is detected; events on disabled lines leave the flag at 0.
- R6: Writing to the clear address (5) clears each flag whose data bit is 1 and whose enable bit is 1, one cycle after the write; data bits of 0 leave their flags unchanged.
- R7: A clear of a line whose enable bit is 0 is ignored and the flag stays set.
- R8: When an event and a clear hit the same flag on the same clock edge, the flag ends set.
- R9: `irq[g]` is the OR of flags 8g to 8g+7.
- R10: With the filter bit 0, a level held across one rising edge is captured: the flag is visible 3 edges after the edge that first samples the pin, and a one-cycle pulse sets it.
- R11: With the filter bit 1, a one-cycle pulse sets no flag, and a level held for two edges sets the flag 4 edges after the first sampling edge.
- R12: While `clk_en` is 0 no flag is set and pin sampling is frozen; a level that differs when `clk_en` returns to 1 is detected 3 edges later, and a pulse that ends while `clk_en` is 0 is never seen.
- R13: Enable, trigger and filter registers read back the last value written; the clear address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Module clock enable; event detection stops while low |
| pins_in | input | 32 | Port input levels, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 4 | Grouped interrupt requests |

## Verification
A line machine stuck in the wrong accepted level shows up on the ports as a missing flag, or as a flag set on the wrong transition. This is visible in the flag register on the third or fourth edge after the pin change, so the bench samples on exactly those edges and one edge earlier. Faulty clear gating or set/clear priority shows up on the first read after the write. A wrong group mapping shows up at once on `irq`, because that output is a plain OR of the flags. A bad freeze during a low clock enable shows up as a flag that appears while it is low, or that is late or missing after it goes high.

// File: rtl/pcw_irq_pkg.sv
package pcw_irq_pkg;

    typedef enum logic [2:0] {
        A_ENABLE  = 3'd0,
        A_TRIG_LO = 3'd1,
        A_TRIG_HI = 3'd2,
        A_FILTER  = 3'd3,
        A_FLAGS   = 3'd4,
        A_CLEAR   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIG_ANY  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        ST_LOW,
        ST_RISING,
        ST_HIGH,
        ST_FALLING
    } line_state_e;

endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else if (adv) begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/pcw_line_fsm.sv
module pcw_line_fsm
    import pcw_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic filt_en,
    input  logic smp,
    output logic rise_ev,
    output logic fall_ev
);

    line_state_e state_q;
    line_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else if (adv) begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (smp) begin
                    state_d = filt_en ? ST_RISING : ST_HIGH;
                end
            end
            ST_RISING: begin
                state_d = smp ? ST_HIGH : ST_LOW;
            end
            ST_HIGH: begin
                if (!smp) begin
                    state_d = filt_en ? ST_FALLING : ST_LOW;
                end
            end
            ST_FALLING: begin
                state_d = smp ? ST_HIGH : ST_LOW;
            end
            default: state_d = ST_LOW;
        endcase
    end

    // outputs
    always_comb begin
        rise_ev = 1'b0;
        fall_ev = 1'b0;
        unique case (state_q)
            ST_LOW:     rise_ev = adv && smp && !filt_en;
            ST_RISING:  rise_ev = adv && smp;
            ST_HIGH:    fall_ev = adv && !smp && !filt_en;
            ST_FALLING: fall_ev = adv && !smp;
            default: begin
                rise_ev = 1'b0;
                fall_ev = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcw_regs.sv
module pcw_regs
    import pcw_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int AW       = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr,
    input  logic [NUM_PINS-1:0] flags_in,
    output logic [NUM_PINS-1:0] rd_data,
    output logic [NUM_PINS-1:0] enable_q,
    output logic [NUM_PINS-1:0] trig_lo_q,
    output logic [NUM_PINS-1:0] trig_hi_q,
    output logic [NUM_PINS-1:0] filter_q,
    output logic [NUM_PINS-1:0] clear_req
);

    reg_addr_e wsel;
    reg_addr_e rsel;

    assign wsel = reg_addr_e'(wr_addr);
    assign rsel = reg_addr_e'(rd_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= '0;
            trig_lo_q <= '0;
            trig_hi_q <= '0;
            filter_q  <= '0;
        end else if (wr_en) begin
            unique case (wsel)
                A_ENABLE:  enable_q  <= wr_data;
                A_TRIG_LO: trig_lo_q <= wr_data;
                A_TRIG_HI: trig_hi_q <= wr_data;
                A_FILTER:  filter_q  <= wr_data;
                default: begin
                end
            endcase
        end
    end

    assign clear_req = (wr_en && wsel == A_CLEAR) ? wr_data : '0;

    always_comb begin
        unique case (rsel)
            A_ENABLE:  rd_data = enable_q;
            A_TRIG_LO: rd_data = trig_lo_q;
            A_TRIG_HI: rd_data = trig_hi_q;
            A_FILTER:  rd_data = filter_q;
            A_FLAGS:   rd_data = flags_in;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pcw_flags.sv
module pcw_flags
    import pcw_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [NUM_PINS-1:0] rise_ev,
    input  logic [NUM_PINS-1:0] fall_ev,
    input  logic [NUM_PINS-1:0] enable,
    input  logic [NUM_PINS-1:0] trig_lo,
    input  logic [NUM_PINS-1:0] trig_hi,
    input  logic [NUM_PINS-1:0] clear_req,
    output logic [NUM_PINS-1:0] flags_q
);

    logic [NUM_PINS-1:0] hit;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
        trig_e mode;
        assign mode = trig_e'({trig_hi[i], trig_lo[i]});
        always_comb begin
            unique case (mode)
                TRIG_RISE: hit[i] = rise_ev[i];
                TRIG_FALL: hit[i] = fall_ev[i];
                default:   hit[i] = rise_ev[i] | fall_ev[i];
            endcase
        end
    end

    logic [NUM_PINS-1:0] set_m;
    logic [NUM_PINS-1:0] clr_m;

    assign set_m = hit & enable & {NUM_PINS{adv}};
    assign clr_m = clear_req & enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_m) | set_m;
        end
    end

endmodule

// File: rtl/pcw_irq_top.sv
module pcw_irq_top
    import pcw_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 8,
    parameter int AW       = 3,
    localparam int GROUPS  = NUM_PINS / GROUP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic [NUM_PINS-1:0] pins_in,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [NUM_PINS-1:0] rd_data,
    output logic [GROUPS-1:0]   irq
);

    logic [NUM_PINS-1:0] smp;
    logic [NUM_PINS-1:0] rise_ev;
    logic [NUM_PINS-1:0] fall_ev;
    logic [NUM_PINS-1:0] enable_q;
    logic [NUM_PINS-1:0] trig_lo_q;
    logic [NUM_PINS-1:0] trig_hi_q;
    logic [NUM_PINS-1:0] filter_q;
    logic [NUM_PINS-1:0] clear_req;
    logic [NUM_PINS-1:0] flags_q;

    pcw_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (clk_en),
        .async_in (pins_in),
        .sync_out (smp)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
        pcw_line_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (clk_en),
            .filt_en (filter_q[i]),
            .smp     (smp[i]),
            .rise_ev (rise_ev[i]),
            .fall_ev (fall_ev[i])
        );
    end

    pcw_regs #(.NUM_PINS(NUM_PINS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .flags_in  (flags_q),
        .rd_data   (rd_data),
        .enable_q  (enable_q),
        .trig_lo_q (trig_lo_q),
        .trig_hi_q (trig_hi_q),
        .filter_q  (filter_q),
        .clear_req (clear_req)
    );

    pcw_flags #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (clk_en),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .enable    (enable_q),
        .trig_lo   (trig_lo_q),
        .trig_hi   (trig_hi_q),
        .clear_req (clear_req),
        .flags_q   (flags_q)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign irq[g] = |flags_q[g*GROUP_W +: GROUP_W];
    end

endmodule

// File: rtl/pcw_irq_chk.sv
module pcw_irq_chk #(
    parameter int NUM_PINS = 32,
    parameter int GROUPS   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clk_en,
    input logic [NUM_PINS-1:0] enable_q,
    input logic [NUM_PINS-1:0] flags_q,
    input logic [GROUPS-1:0]   irq
);

    // R1: reset leaves every flag cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0));

    // R5: a newly set flag needs its enable bit
    a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~$past(flags_q) & ~$past(enable_q)) == '0));

    // R7: a flag only drops while its enable bit is set
    a_r7_clear_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags_q & $past(flags_q) & ~$past(enable_q)) == '0));

    // R12: no new flag after an edge with the clock enable low
    a_r12_gate_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ((flags_q & ~$past(flags_q)) == '0));

    // R9: some request is active exactly when some flag is set
    a_r9_any_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq != '0) == (flags_q != '0)));

endmodule

bind pcw_irq_top pcw_irq_chk #(.NUM_PINS(NUM_PINS), .GROUPS(GROUPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .enable_q (enable_q),
    .flags_q  (flags_q),
    .irq      (irq)
);

// File: tb/sim_pcw_irq_top.sv
module sim_pcw_irq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic [31:0] pins_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd4;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    localparam logic [2:0] AD_ENA = 3'd0, AD_TLO = 3'd1, AD_THI = 3'd2,
                           AD_FLT = 3'd3, AD_FLG = 3'd4, AD_CLR = 3'd5;

    pcw_irq_top u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pins_in(pins_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          q_due[$];
    bit          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_req[$];

    task automatic push(input int d, input bit kind, input logic [31:0] exp, input string req);
        q_due.push_back(cyc + d);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_req.push_back(req);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        push(1, 1'b0, exp, req);
        tick(1);
        rd_addr = AD_FLG;
    endtask

    task automatic clear_and_check(input logic [31:0] m, input string req);
        wr(AD_CLR, m);
        push(1, 1'b0, 32'h0, req);
        tick(1);
    endtask

    // monitor: compares queued expectations when their cycle comes
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q_due.size() > 0 && q_due[0] <= cyc) begin
                logic [31:0] act;
                act = q_kind[0] ? {28'd0, irq} : rd_data;
                checks++;
                if (q_due[0] < cyc) begin
                    errors++;
                    $display("FAIL %s: check missed its cycle, got %h expected %h", q_req[0], act, q_exp[0]);
                end else if (act !== q_exp[0]) begin
                    errors++;
                    $display("FAIL %s: %s got %h expected %h", q_req[0],
                             q_kind[0] ? "irq" : "rd_data", act, q_exp[0]);
                end
                void'(q_due.pop_front());
                void'(q_kind.pop_front());
                void'(q_exp.pop_front());
                void'(q_req.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd_check(AD_ENA, 32'h0, "R1");
        rd_check(AD_TLO, 32'h0, "R1");
        rd_check(AD_THI, 32'h0, "R1");
        rd_check(AD_FLT, 32'h0, "R1");
        rd_check(AD_FLG, 32'h0, "R1");
        push(1, 1'b1, 32'h0, "R1"); tick(1);

        // R13 register readback
        wr(AD_ENA, 32'hFFFF_FFFF);
        wr(AD_TLO, 32'h0000_0006);
        wr(AD_THI, 32'h0000_000A);
        rd_check(AD_ENA, 32'hFFFF_FFFF, "R13");
        rd_check(AD_TLO, 32'h0000_0006, "R13");
        rd_check(AD_THI, 32'h0000_000A, "R13");
        rd_check(AD_CLR, 32'h0, "R13");

        // R2 / R10: any-change line 0, filter off
        pins_in[0] = 1'b1;
        push(2, 1'b0, 32'h0, "R10");
        push(3, 1'b0, 32'h1, "R2");
        tick(4);
        clear_and_check(32'h1, "R6");
        pins_in[0] = 1'b0;
        push(2, 1'b0, 32'h0, "R10");
        push(3, 1'b0, 32'h1, "R2");
        tick(4);
        clear_and_check(32'h1, "R6");

        // R2: mode 11 on line 1
        pins_in[1] = 1'b1;
        push(3, 1'b0, 32'h2, "R2"); tick(4);
        clear_and_check(32'h2, "R6");
        pins_in[1] = 1'b0;
        push(3, 1'b0, 32'h2, "R2"); tick(4);
        clear_and_check(32'h2, "R6");

        // R3: rising only on line 2
        pins_in[2] = 1'b1;
        push(3, 1'b0, 32'h4, "R3"); tick(4);
        clear_and_check(32'h4, "R6");
        pins_in[2] = 1'b0;
        push(3, 1'b0, 32'h0, "R3");
        push(6, 1'b0, 32'h0, "R3"); tick(7);

        // R4: falling only on line 3
        pins_in[3] = 1'b1;
        push(3, 1'b0, 32'h0, "R4");
        push(6, 1'b0, 32'h0, "R4"); tick(7);
        pins_in[3] = 1'b0;
        push(3, 1'b0, 32'h8, "R4"); tick(4);
        wr(AD_CLR, ~32'h8);
        push(1, 1'b0, 32'h8, "R6"); tick(1);
        clear_and_check(32'h8, "R6");

        // R9: grouping, lines 8 and 31
        pins_in[8] = 1'b1; pins_in[31] = 1'b1;
        push(2, 1'b1, 32'h0, "R9");
        push(3, 1'b1, 32'hA, "R9"); tick(4);
        wr(AD_CLR, 32'h0000_0100);
        push(1, 1'b1, 32'h8, "R9"); tick(1);
        wr(AD_CLR, 32'h8000_0000);
        push(1, 1'b1, 32'h0, "R9"); tick(1);
        pins_in[8] = 1'b0; pins_in[31] = 1'b0;
        tick(4);
        wr(AD_CLR, 32'h8000_0100);
        push(1, 1'b1, 32'h0, "R9"); tick(1);

        // R5: disabled line 4 never flags
        wr(AD_ENA, ~32'h10);
        pins_in[4] = 1'b1;
        push(3, 1'b0, 32'h0, "R5");
        push(3, 1'b1, 32'h0, "R5");
        push(5, 1'b0, 32'h0, "R5"); tick(6);
        pins_in[4] = 1'b0; tick(4);
        push(1, 1'b0, 32'h0, "R5"); tick(1);

        // R7: clear ignored on a disabled line
        pins_in[5] = 1'b1;
        push(3, 1'b0, 32'h20, "R5"); tick(4);
        wr(AD_ENA, ~32'h30);
        wr(AD_CLR, 32'h20);
        push(1, 1'b0, 32'h20, "R7"); tick(1);
        push(1, 1'b1, 32'h1, "R7"); tick(1);
        wr(AD_ENA, 32'hFFFF_FFFF);
        clear_and_check(32'h20, "R7");

        // R8: set beats clear on the same edge (line 6)
        pins_in[6] = 1'b1;
        tick(2);
        wr(AD_CLR, 32'h40);
        push(1, 1'b0, 32'h40, "R8"); tick(2);
        clear_and_check(32'h40, "R8");

        // R10: one-cycle pulse caught with filter off (line 0)
        pins_in[0] = 1'b1; tick(1); pins_in[0] = 1'b0;
        push(2, 1'b0, 32'h1, "R10"); tick(6);
        clear_and_check(32'h1, "R10");

        // R11: filter on line 7
        wr(AD_FLT, 32'h80);
        rd_check(AD_FLT, 32'h80, "R13");
        pins_in[7] = 1'b1; tick(1); pins_in[7] = 1'b0;
        push(2, 1'b0, 32'h0, "R11");
        push(6, 1'b0, 32'h0, "R11"); tick(7);
        pins_in[7] = 1'b1;
        push(3, 1'b0, 32'h0, "R11");
        push(4, 1'b0, 32'h80, "R11"); tick(5);
        clear_and_check(32'h80, "R11");
        pins_in[7] = 1'b0;
        push(3, 1'b0, 32'h0, "R11");
        push(4, 1'b0, 32'h80, "R11"); tick(5);
        clear_and_check(32'h80, "R11");

        // R12: clock enable gating on line 9
        clk_en = 1'b0;
        pins_in[9] = 1'b1; tick(3); pins_in[9] = 1'b0;
        push(3, 1'b0, 32'h0, "R12"); tick(4);
        clk_en = 1'b1;
        push(6, 1'b0, 32'h0, "R12"); tick(7);
        clk_en = 1'b0;
        pins_in[9] = 1'b1;
        push(4, 1'b0, 32'h0, "R12"); tick(5);
        clk_en = 1'b1;
        push(2, 1'b0, 32'h0, "R12");
        push(3, 1'b0, 32'h200, "R12"); tick(4);
        clear_and_check(32'h200, "R12");

        tick(3);
        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", q_due.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule